// File: doc/BRIEF.md
# Trigger-Accept Readout Buffer

This block sits between a set of finder sources and a narrow readout link. Every source writes 32-bit slices into its own ring of crossing slots on every cycle it marks valid, with no gating. Twenty-four slices make up one crossing, which is eight cells of three slices each. A crossing that no accept ever claims stays in place until its slot comes round again, and the ring then overwrites it.

When the accept strobe arrives, the block records, separately for each source, which crossing slot that source finished most recently. A drain sequencer later walks those slots. It selects one source at a time through a five-way selector and splits each 32-bit slice into two 16-bit link words, sending one word per clock. The fifth source counts as half a source, so only its first four cells are read. One event is therefore 216 words long, and its last word carries an end-of-event marker. Accepts that arrive while an event is draining wait in a short queue. If an accept arrives when that queue is full, it is lost and a sticky flag is raised.

Top module: `l1a_readout_buffer`

## Requirements
- R1: While reset is applied and after it is released, link_valid, link_eoe and overflow are low, and they stay low until an accept is given.
- R2: Each source fills slices 0 to 23 of its current crossing in the order its valid words arrive, and the 24th word completes that crossing. An accept reads, for each source independently, the crossing that source completed most recently.
- R3: An event is 216 link words. Sources 0 to 3 contribute all 24 slices and source 4 contributes only slices 0 to 11. Sources go out in ascending order, and within a source the slices go out in ascending order.
- R4: Each slice goes out as two words: bits 31:16 first, then bits 15:0.
- R5: The words of one event appear on consecutive clock cycles. No word appears outside an accepted event.
- R6: link_eoe is high only together with the 216th word of an event.
- R7: Each source keeps 16 crossing slots. A crossing that is not accepted is overwritten by the crossing that comes 16 later, so an accept given after 17 crossings returns the 17th.
- R8: An accept that arrives while an event is draining is queued. Up to 4 events can wait behind the one being drained, and they are sent in arrival order.
- R9: An accept that arrives while 4 events are already waiting is dropped and sets overflow. Overflow stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| src_valid | input | 5 | One write strobe per source |
| src_data | input | 160 | Source slices; source s occupies bits 32*s+31 down to 32*s |
| accept | input | 1 | Accept strobe, one cycle per accepted crossing |
| link_word | output | 16 | Outgoing 16-bit link word |
| link_valid | output | 1 | link_word carries a word of an event |
| link_eoe | output | 1 | Marks the last word of an event |
| overflow | output | 1 | Sticky flag: an accept was lost because the queue was full |

## Verification
The hardest state to reach from the ports is a full accept queue: one event draining, four more waiting, and one further accept arriving. The bench gets there with six accept strobes on consecutive cycles straight after an idle period, then checks that exactly five events come out and that the flag stays set. A second hard situation is a waiting event whose slot could be overwritten by sources that keep writing during a drain. The random phase keeps writing crossings with random per-source gaps while events drain, and it compares every word against the crossing each source had completed at the time of the accept.

// File: rtl/rdbuf_pkg.sv
package rdbuf_pkg;

  localparam int DEF_SRC_COUNT     = 5;
  localparam int DEF_SLICE_BITS    = 32;
  localparam int DEF_LINK_BITS     = 16;
  localparam int DEF_CELLS_PER_SRC = 8;
  localparam int DEF_SLICES_PER_CELL = 3;
  localparam int DEF_TAIL_CELLS    = 4;
  localparam int DEF_XING_SLOTS    = 16;
  localparam int DEF_PEND_DEPTH    = 4;

  typedef enum logic [1:0] {
    DR_IDLE  = 2'd0,
    DR_FETCH = 2'd1,
    DR_SEND  = 2'd2
  } drain_state_e;

endpackage

// File: rtl/rdbuf_src_ring.sv
module rdbuf_src_ring #(
  parameter int SLICE_BITS = 32,
  parameter int XING_SLOTS = 16,
  parameter int SLICES     = 24,
  localparam int SLOT_W    = $clog2(XING_SLOTS),
  localparam int IDX_W     = $clog2(SLICES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_valid,
  input  logic [SLICE_BITS-1:0] wr_data,
  output logic [SLOT_W-1:0]     done_slot,
  input  logic [SLOT_W-1:0]     rd_slot,
  input  logic [IDX_W-1:0]      rd_idx,
  output logic [SLICE_BITS-1:0] rd_data
);

  localparam int ENTRIES = XING_SLOTS * SLICES;
  localparam int ADDR_W  = $clog2(ENTRIES);

  logic [SLICE_BITS-1:0] store [ENTRIES];

  logic [IDX_W-1:0]  widx_q, widx_d;
  logic [SLOT_W-1:0] wslot_q, wslot_d;
  logic [SLOT_W-1:0] done_q, done_d;
  logic [ADDR_W-1:0] wr_addr, rd_addr;

  // write pointer: slice index inside a crossing, crossing slot inside the ring
  always_comb begin
    widx_d  = widx_q;
    wslot_d = wslot_q;
    done_d  = done_q;
    if (widx_q == IDX_W'(SLICES - 1)) begin
      widx_d = '0;
      done_d = wslot_q;
      if (wslot_q == SLOT_W'(XING_SLOTS - 1)) begin
        wslot_d = '0;
      end else begin
        wslot_d = wslot_q + 1'b1;
      end
    end else begin
      widx_d = widx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      widx_q  <= '0;
      wslot_q <= '0;
      done_q  <= '0;
    end else if (wr_valid) begin
      widx_q  <= widx_d;
      wslot_q <= wslot_d;
      done_q  <= done_d;
    end
  end

  assign wr_addr = ADDR_W'(wslot_q) * ADDR_W'(SLICES) + ADDR_W'(widx_q);
  assign rd_addr = ADDR_W'(rd_slot) * ADDR_W'(SLICES) + ADDR_W'(rd_idx);

  always_ff @(posedge clk) begin
    if (wr_valid) begin
      store[wr_addr] <= wr_data;
    end
  end

  assign rd_data   = store[rd_addr];
  assign done_slot = done_q;

  AST_WIDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    widx_q < IDX_W'(SLICES)); // R2

endmodule

// File: rtl/rdbuf_accept_queue.sv
module rdbuf_accept_queue #(
  parameter int ENTRY_BITS = 20,
  parameter int DEPTH      = 4,
  localparam int PTR_W     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W     = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  push,
  input  logic [ENTRY_BITS-1:0] push_entry,
  input  logic                  pop,
  output logic [ENTRY_BITS-1:0] head_entry,
  output logic                  empty,
  output logic                  overflow
);

  logic [ENTRY_BITS-1:0] slots [DEPTH];

  logic [PTR_W-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ovf_q, ovf_d;
  logic             take;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    if (p == PTR_W'(DEPTH - 1)) begin
      return '0;
    end
    return p + 1'b1;
  endfunction

  assign take = push && (cnt_q != CNT_W'(DEPTH));

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    ovf_d = ovf_q;
    if (push && !take) begin
      ovf_d = 1'b1;
    end
    if (take) begin
      wp_d = ptr_inc(wp_q);
    end
    if (pop) begin
      rp_d = ptr_inc(rp_q);
    end
    case ({take, pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      slots[wp_q] <= push_entry;
    end
  end

  assign head_entry = slots[rp_q];
  assign empty      = (cnt_q == '0);
  assign overflow   = ovf_q;

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH)); // R8
  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt_q != '0)); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q); // R9
  AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_q) |-> $past(push)); // R9

endmodule

// File: rtl/rdbuf_drain.sv
module rdbuf_drain
  import rdbuf_pkg::*;
#(
  parameter int SRC_COUNT   = 5,
  parameter int SLICE_BITS  = 32,
  parameter int LINK_BITS   = 16,
  parameter int SLICES      = 24,
  parameter int TAIL_SLICES = 12,
  parameter int SLOT_W      = 4,
  localparam int SRC_W      = $clog2(SRC_COUNT),
  localparam int IDX_W      = $clog2(SLICES),
  localparam int PARTS      = SLICE_BITS / LINK_BITS,
  localparam int PART_W     = (PARTS > 1) ? $clog2(PARTS) : 1,
  localparam int DESC_BITS  = SRC_COUNT * SLOT_W
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            q_empty,
  input  logic [DESC_BITS-1:0]            q_head,
  output logic                            q_pop,
  output logic [DESC_BITS-1:0]            rd_slots,
  output logic [IDX_W-1:0]                rd_idx,
  input  logic [SRC_COUNT*SLICE_BITS-1:0] rd_bus,
  output logic [LINK_BITS-1:0]            link_word,
  output logic                            link_valid,
  output logic                            link_eoe
);

  drain_state_e state_q, state_d;
  logic [SRC_W-1:0]      src_q, src_d;
  logic [IDX_W-1:0]      idx_q, idx_d;
  logic [PART_W-1:0]     part_q, part_d;
  logic [DESC_BITS-1:0]  desc_q, desc_d;
  logic [SLICE_BITS-1:0] slice_q;
  logic [SLICE_BITS-1:0] lane [SRC_COUNT];
  logic [SLICE_BITS-1:0] lane_sel;
  logic                  load_slice;
  logic                  word_en;
  logic                  valid_d, eoe_d;
  logic [LINK_BITS-1:0]  word_d;
  logic [LINK_BITS-1:0]  word_q;
  logic                  valid_q, eoe_q;

  for (genvar g = 0; g < SRC_COUNT; g++) begin : g_lane
    assign lane[g] = rd_bus[g*SLICE_BITS +: SLICE_BITS];
  end

  function automatic logic [IDX_W-1:0] last_idx(input logic [SRC_W-1:0] s);
    if (s == SRC_W'(SRC_COUNT - 1)) begin
      return IDX_W'(TAIL_SLICES - 1);
    end
    return IDX_W'(SLICES - 1);
  endfunction

  always_comb begin
    state_d    = state_q;
    src_d      = src_q;
    idx_d      = idx_q;
    part_d     = part_q;
    desc_d     = desc_q;
    q_pop      = 1'b0;
    load_slice = 1'b0;
    word_en    = 1'b0;
    valid_d    = 1'b0;
    eoe_d      = 1'b0;
    case (state_q)
      DR_IDLE: begin
        if (!q_empty) begin
          q_pop   = 1'b1;
          desc_d  = q_head;
          src_d   = '0;
          idx_d   = '0;
          part_d  = '0;
          state_d = DR_FETCH;
        end
      end
      DR_FETCH: begin
        load_slice = 1'b1;
        state_d    = DR_SEND;
      end
      DR_SEND: begin
        word_en = 1'b1;
        valid_d = 1'b1;
        if (part_q != PART_W'(PARTS - 1)) begin
          part_d = part_q + 1'b1;
        end else begin
          part_d = '0;
          if (idx_q == last_idx(src_q)) begin
            if (src_q == SRC_W'(SRC_COUNT - 1)) begin
              eoe_d   = 1'b1;
              state_d = DR_IDLE;
            end else begin
              src_d      = src_q + 1'b1;
              idx_d      = '0;
              load_slice = 1'b1;
            end
          end else begin
            idx_d      = idx_q + 1'b1;
            load_slice = 1'b1;
          end
        end
      end
      default: state_d = DR_IDLE;
    endcase
  end

  // read address follows the next counters so the slice lands as the last part leaves
  assign rd_idx   = idx_d;
  assign rd_slots = desc_q;
  assign lane_sel = lane[src_d];
  assign word_d   = slice_q[SLICE_BITS - 1 - int'(part_q) * LINK_BITS -: LINK_BITS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= DR_IDLE;
      src_q   <= '0;
      idx_q   <= '0;
      part_q  <= '0;
      desc_q  <= '0;
      valid_q <= 1'b0;
      eoe_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      src_q   <= src_d;
      idx_q   <= idx_d;
      part_q  <= part_d;
      desc_q  <= desc_d;
      valid_q <= valid_d;
      eoe_q   <= eoe_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slice_q <= '0;
    end else if (load_slice) begin
      slice_q <= lane_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (word_en) begin
      word_q <= word_d;
    end
  end

  assign link_word  = word_q;
  assign link_valid = valid_q;
  assign link_eoe   = eoe_q;

  AST_EOE_WITH_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    link_eoe |-> link_valid); // R6
  AST_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (link_valid && !link_eoe) |=> link_valid); // R5
  AST_SRC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    src_q < SRC_W'(SRC_COUNT)); // R3

endmodule

// File: rtl/l1a_readout_buffer.sv
module l1a_readout_buffer
  import rdbuf_pkg::*;
#(
  parameter int SRC_COUNT       = DEF_SRC_COUNT,
  parameter int SLICE_BITS      = DEF_SLICE_BITS,
  parameter int LINK_BITS       = DEF_LINK_BITS,
  parameter int CELLS_PER_SRC   = DEF_CELLS_PER_SRC,
  parameter int SLICES_PER_CELL = DEF_SLICES_PER_CELL,
  parameter int TAIL_CELLS      = DEF_TAIL_CELLS,
  parameter int XING_SLOTS      = DEF_XING_SLOTS,
  parameter int PEND_DEPTH      = DEF_PEND_DEPTH
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [SRC_COUNT-1:0]            src_valid,
  input  logic [SRC_COUNT*SLICE_BITS-1:0] src_data,
  input  logic                            accept,
  output logic [LINK_BITS-1:0]            link_word,
  output logic                            link_valid,
  output logic                            link_eoe,
  output logic                            overflow
);

  localparam int SLICES      = CELLS_PER_SRC * SLICES_PER_CELL;
  localparam int TAIL_SLICES = TAIL_CELLS * SLICES_PER_CELL;
  localparam int SLOT_W      = $clog2(XING_SLOTS);
  localparam int IDX_W       = $clog2(SLICES);
  localparam int DESC_BITS   = SRC_COUNT * SLOT_W;

  logic [1:0]                      rst_pipe_q;
  logic                            rst_n_int;
  logic [DESC_BITS-1:0]            done_flat;
  logic [DESC_BITS-1:0]            rd_slots;
  logic [IDX_W-1:0]                rd_idx;
  logic [SRC_COUNT*SLICE_BITS-1:0] rd_bus;
  logic [DESC_BITS-1:0]            q_head;
  logic                            q_empty;
  logic                            q_pop;

  // assert asynchronously, release on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_n_int = rst_pipe_q[1];

  for (genvar s = 0; s < SRC_COUNT; s++) begin : g_src
    rdbuf_src_ring #(
      .SLICE_BITS (SLICE_BITS),
      .XING_SLOTS (XING_SLOTS),
      .SLICES     (SLICES)
    ) u_ring (
      .clk       (clk),
      .rst_n     (rst_n_int),
      .wr_valid  (src_valid[s]),
      .wr_data   (src_data[s*SLICE_BITS +: SLICE_BITS]),
      .done_slot (done_flat[s*SLOT_W +: SLOT_W]),
      .rd_slot   (rd_slots[s*SLOT_W +: SLOT_W]),
      .rd_idx    (rd_idx),
      .rd_data   (rd_bus[s*SLICE_BITS +: SLICE_BITS])
    );
  end

  rdbuf_accept_queue #(
    .ENTRY_BITS (DESC_BITS),
    .DEPTH      (PEND_DEPTH)
  ) u_queue (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .push       (accept),
    .push_entry (done_flat),
    .pop        (q_pop),
    .head_entry (q_head),
    .empty      (q_empty),
    .overflow   (overflow)
  );

  rdbuf_drain #(
    .SRC_COUNT   (SRC_COUNT),
    .SLICE_BITS  (SLICE_BITS),
    .LINK_BITS   (LINK_BITS),
    .SLICES      (SLICES),
    .TAIL_SLICES (TAIL_SLICES),
    .SLOT_W      (SLOT_W)
  ) u_drain (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .q_empty    (q_empty),
    .q_head     (q_head),
    .q_pop      (q_pop),
    .rd_slots   (rd_slots),
    .rd_idx     (rd_idx),
    .rd_bus     (rd_bus),
    .link_word  (link_word),
    .link_valid (link_valid),
    .link_eoe   (link_eoe)
  );

endmodule

// File: tb/sim_l1a_readout_buffer.sv
module sim_l1a_readout_buffer;

  localparam int NS    = 5;
  localparam int SW    = 32;
  localparam int FULL  = 24;
  localparam int TAIL  = 12;
  localparam int EVW   = 2 * (4 * FULL + TAIL);
  localparam int SLOTS = 16;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NS-1:0]   src_valid;
  logic [NS*SW-1:0] src_data;
  logic            accept;
  logic [15:0]     link_word;
  logic            link_valid;
  logic            link_eoe;
  logic            overflow;

  always #5 clk = ~clk;

  l1a_readout_buffer u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_valid  (src_valid),
    .src_data   (src_data),
    .accept     (accept),
    .link_word  (link_word),
    .link_valid (link_valid),
    .link_eoe   (link_eoe),
    .overflow   (overflow)
  );

  int          n_cmp = 0;
  int          n_bad = 0;
  logic [31:0] salt;
  int          xcnt [NS];
  int          exp_x [$];
  string       exp_tag [$];
  int          widx = 0;
  int          ev_done = 0;
  bit          run = 0;
  bit          finished = 0;

  function automatic logic [31:0] pat(int s, int x, int sl);
    return salt ^ (32'(x) * 32'h9E3779B1) ^ (32'(sl) * 32'h85EBCA6B) ^ {8'(s + 1), 24'h00A5C3};
  endfunction

  function automatic int lim(int s);
    return (s == NS - 1) ? TAIL : FULL;
  endfunction

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  // link monitor: expected word from the crossing each source had completed at accept time
  always @(negedge clk) begin
    if (run) begin
      if (link_valid) begin
        if (exp_x.size() < NS) begin
          check(1'b0, "R5", "word outside any event", 32'(link_word), 32'h0);
        end else begin
          automatic int rem = widx;
          automatic int s = 0;
          automatic int sl;
          automatic int h;
          automatic logic [31:0] d;
          automatic logic [15:0] ew;
          while (rem >= 2 * lim(s)) begin
            rem -= 2 * lim(s);
            s++;
          end
          sl = rem / 2;
          h  = rem % 2;
          d  = pat(s, exp_x[s], sl);
          ew = (h == 0) ? d[31:16] : d[15:0];
          check(link_word == ew, {exp_tag[0], " R3 R4"}, $sformatf("word %0d src %0d slice %0d", widx, s, sl),
                32'(link_word), 32'(ew));
          check(link_eoe == (widx == EVW - 1), "R6", $sformatf("end marker at word %0d", widx),
                32'(link_eoe), 32'(widx == EVW - 1));
          if (widx == EVW - 1) begin
            for (int k = 0; k < NS; k++) void'(exp_x.pop_front());
            void'(exp_tag.pop_front());
            widx = 0;
            ev_done++;
          end else begin
            widx++;
          end
        end
      end else begin
        if (widx != 0) check(1'b0, "R5", "gap inside event", 32'(widx), 32'h0);
        if (link_eoe)  check(1'b0, "R6", "marker without word", 32'h1, 32'h0);
      end
    end
  end

  task automatic write_xings(int n);
    int left [NS];
    int idx [NS];
    bit busy;
    for (int s = 0; s < NS; s++) begin
      left[s] = n;
      idx[s]  = 0;
    end
    busy = 1'b1;
    while (busy) begin
      @(negedge clk);
      busy = 1'b0;
      for (int s = 0; s < NS; s++) begin
        if (left[s] > 0 && ($urandom % 3 != 0)) begin
          src_valid[s] = 1'b1;
          src_data[s*SW +: SW] = pat(s, xcnt[s] + 1, idx[s]);
          idx[s]++;
          if (idx[s] == FULL) begin
            idx[s] = 0;
            xcnt[s]++;
            left[s]--;
          end
        end else begin
          src_valid[s] = 1'b0;
        end
        if (left[s] > 0) busy = 1'b1;
      end
    end
    @(negedge clk);
    src_valid = '0;
  endtask

  task automatic record(string tag);
    for (int s = 0; s < NS; s++) exp_x.push_back(xcnt[s]);
    exp_tag.push_back(tag);
  endtask

  task automatic do_accept(string tag);
    @(negedge clk);
    accept = 1'b1;
    record(tag);
    @(negedge clk);
    accept = 1'b0;
  endtask

  task automatic wait_drain();
    while (exp_x.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    int base;
    salt = $urandom(32'd2024);
    salt = $urandom;
    for (int s = 0; s < NS; s++) xcnt[s] = 0;
    rst_n = 1'b0;
    src_valid = '0;
    src_data = '0;
    accept = 1'b0;
    repeat (3) @(negedge clk);
    check(!link_valid && !link_eoe && !overflow, "R1", "outputs during reset",
          {29'h0, link_valid, link_eoe, overflow}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run = 1'b1;
    check(!link_valid && !link_eoe && !overflow, "R1", "outputs after reset",
          {29'h0, link_valid, link_eoe, overflow}, 32'h0);

    // R1: source writes alone produce nothing on the link
    write_xings(1);
    repeat (5) @(negedge clk);
    check(!link_valid && !overflow, "R1", "quiet without accept",
          {30'h0, link_valid, overflow}, 32'h0);

    // R3: a single event, words checked by the monitor
    do_accept("R3");
    wait_drain();
    check(ev_done == 1, "R3", "events after first accept", 32'(ev_done), 32'd1);

    // R8 R9: one draining, four waiting, sixth accept lost
    write_xings(1);
    base = ev_done;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      accept = 1'b1;
      record("R8");
    end
    @(negedge clk);
    check(overflow == 1'b0, "R9", "flag before sixth accept", 32'(overflow), 32'h0);
    accept = 1'b1;
    @(negedge clk);
    accept = 1'b0;
    check(overflow == 1'b1, "R9", "flag after dropped accept", 32'(overflow), 32'h1);
    wait_drain();
    check(ev_done - base == 5, "R8", "events from burst", 32'(ev_done - base), 32'd5);
    check(overflow == 1'b1, "R9", "flag held after drain", 32'(overflow), 32'h1);

    // R7: ring wraps, the oldest crossing is gone
    write_xings(SLOTS + 1);
    do_accept("R7");
    wait_drain();

    // R2: random crossings with writes running during drains
    for (int it = 0; it < 40; it++) begin
      while (exp_x.size() / NS >= 2) @(negedge clk);
      write_xings(1 + int'($urandom % 2));
      if ($urandom % 2 == 1) do_accept("R2");
    end
    wait_drain();
    check(link_valid == 1'b0, "R5", "link idle at end", 32'(link_valid), 32'h0);
    check(overflow == 1'b1, "R9", "flag still held at end", 32'(overflow), 32'h1);
    check(ev_done >= 8, "R2", "events delivered overall", 32'(ev_done), 32'd8);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R5 watchdog expired actual=%0d expected=%0d", ev_done, 0);
      finish_run();
    end
  end

endmodule